// File: doc/BRIEF.md
# UART Line Status Flag Logic

This block produces the line status flags of a UART that has a transmit FIFO and a receive FIFO. On the transmit side it tracks whether the holding stage and the transmit shift register hold a character. From that it drives a "holding empty" flag and an "all transmit stages empty" flag, plus an interrupt request gated by an enable input. The holding-empty flag follows different rules in FIFO mode and in single-holding-register mode. In FIFO mode the transmit FIFO's own empty signal is used.

On the receive side the block keeps a small FIFO of 3-bit error tags, one per received byte, in step with the byte storage held elsewhere. The parity, framing and break outputs always describe the byte at the head of the receive FIFO, which is the byte the next data read returns. Software therefore reads status first and data second. A summary error bit is sticky and clears on a status read. It comes back at once while error-tagged bytes remain queued. The block keeps a running count of the tagged bytes for this purpose.

Top module: `uart_line_status`

## Requirements
- R1: After reset, thre and temt are 1, and err_par, err_frm, err_brk and err_any are 0.
- R2: With fifo_mode=0, a holding stage is full from the clock edge that samples thr_wr until the edge that samples tsr_load with no thr_wr in the same cycle. thre is the inverse of that full state, so thre reads 0 in the cycle after the write.
- R3: With fifo_mode=1, thre equals tx_fifo_empty in the same cycle, and thr_wr has no effect on thre or temt.
- R4: The shift register is busy from the edge that samples tsr_load until the edge that samples tsr_done without tsr_load. temt is 1 only while thre is 1 and the shift register is not busy.
- R5: tx_irq is 1 exactly when thre is 1 and thr_irq_en is 1.
- R6: rx_tag bit 0 is a parity error, bit 1 a framing error and bit 2 a break. err_par, err_frm and err_brk show those bits of the head entry of the receive tag FIFO, and are all 0 while that FIFO is empty.
- R7: The tag FIFO holds DEPTH entries in arrival order. A push when full is dropped unless a pop happens in the same cycle. A pop when empty is ignored.
- R8: err_any after an edge equals (err_any before the edge AND no lsr_rd) OR (at least one error-tagged entry is in the FIFO after the edge).
- R9: When lsr_rd and rx_pop fall in the same cycle, the outputs in that cycle show the pre-pop head tag and err_any. err_any then clears only if no error-tagged entry remains after the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single holding register mode |
| thr_wr | input | 1 | CPU write to the transmit holding location |
| tx_fifo_empty | input | 1 | Transmit FIFO empty (FIFO mode) |
| tsr_load | input | 1 | Transmitter moves a byte into its shift register |
| tsr_done | input | 1 | Shift register finished its character |
| thr_irq_en | input | 1 | Holding-empty interrupt enable |
| rx_push | input | 1 | Receiver stores a byte |
| rx_tag | input | 3 | Error tag of the pushed byte {break, framing, parity} |
| rx_pop | input | 1 | CPU data read of the receive FIFO |
| lsr_rd | input | 1 | CPU status read |
| thre | output | 1 | Transmit holding empty |
| temt | output | 1 | Transmitter completely empty |
| err_par | output | 1 | Parity error of head byte |
| err_frm | output | 1 | Framing error of head byte |
| err_brk | output | 1 | Break on head byte |
| err_any | output | 1 | Sticky summary error |
| tx_irq | output | 1 | Holding-empty interrupt request |

## Verification
A status read and a data read can fall in the same cycle. On the transmit side, a holding write and a shift-register load can fall in the same cycle as well. The bench drives every combination of these strobes from a deterministic generator, including reads that coincide with pops and pushes into a full FIFO. Each cycle's outputs are judged against a queue model: err_any is derived by scanning the model queue for tagged entries, and the head bits are taken from the model's front entry before the pop takes effect.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } err_tag_t;

  function automatic logic tag_has_err(input err_tag_t t);
    return t.brk | t.frm | t.par;
  endfunction

  function automatic logic [15:0] err_count_next(input logic [15:0] cnt,
                                                 input logic inc,
                                                 input logic dec);
    return cnt + {15'd0, inc} - {15'd0, dec};
  endfunction
endpackage

// File: rtl/lsr_tx_flags.sv
module lsr_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic thr_wr,
  input  logic tx_fifo_empty,
  input  logic tsr_load,
  input  logic tsr_done,
  input  logic thr_irq_en,
  output logic thre,
  output logic temt,
  output logic tx_irq
);
  logic hold_full_q;
  logic tsr_busy_q;
  wire  hold_write_ev = thr_wr & ~fifo_mode;
  wire  hold_drain_ev = tsr_load & ~thr_wr & ~fifo_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full_q <= 1'b0;
      tsr_busy_q  <= 1'b0;
    end else begin
      if (fifo_mode)          hold_full_q <= 1'b0;
      else if (hold_write_ev) hold_full_q <= 1'b1;
      else if (hold_drain_ev) hold_full_q <= 1'b0;
      if (tsr_load)           tsr_busy_q  <= 1'b1;
      else if (tsr_done)      tsr_busy_q  <= 1'b0;
    end
  end

  assign thre   = fifo_mode ? tx_fifo_empty : ~hold_full_q;
  assign temt   = thre & ~tsr_busy_q;
  assign tx_irq = thre & thr_irq_en;

  assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_write_ev |=> hold_full_q);
  assert_drain_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_drain_ev |=> !hold_full_q);
  assert_load_blocks_temt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tsr_load |=> !temt);
endmodule

// File: rtl/lsr_rx_tags.sv
module lsr_rx_tags #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_push,
  input  lsr_pkg::err_tag_t rx_tag,
  input  logic             rx_pop,
  input  logic             lsr_rd,
  output lsr_pkg::err_tag_t head_tag,
  output logic             err_any
);
  import lsr_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  err_tag_t        mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   fill_q, err_cnt_q, err_cnt_n;
  logic            any_q;

  wire fifo_empty = (fill_q == '0);
  wire fifo_full  = (fill_q == CW'(DEPTH));
  wire pop_ok     = rx_pop & ~fifo_empty;
  wire push_ok    = rx_push & (~fifo_full | pop_ok);
  wire err_in_ev  = push_ok & tag_has_err(rx_tag);
  wire err_out_ev = pop_ok & tag_has_err(mem[rd_ptr]);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign err_cnt_n = CW'(err_count_next(16'(err_cnt_q), err_in_ev, err_out_ev));

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= rx_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      fill_q    <= '0;
      err_cnt_q <= '0;
      any_q     <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      fill_q    <= fill_q + CW'(push_ok) - CW'(pop_ok);
      err_cnt_q <= err_cnt_n;
      any_q     <= (any_q & ~lsr_rd) | (err_cnt_n != '0);
    end
  end

  assign head_tag = fifo_empty ? '0 : mem[rd_ptr];
  assign err_any  = any_q;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(DEPTH));
  assert_errcnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt_q <= fill_q);
  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt_q != '0) && !lsr_rd |=> err_any);
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !rx_push && (err_cnt_q == '0) |=> !err_any);
  assert_empty_head_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !tag_has_err(head_tag));
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       thr_wr,
  input  logic       tx_fifo_empty,
  input  logic       tsr_load,
  input  logic       tsr_done,
  input  logic       thr_irq_en,
  input  logic       rx_push,
  input  logic [2:0] rx_tag,
  input  logic       rx_pop,
  input  logic       lsr_rd,
  output logic       thre,
  output logic       temt,
  output logic       err_par,
  output logic       err_frm,
  output logic       err_brk,
  output logic       err_any,
  output logic       tx_irq
);
  import lsr_pkg::*;
  err_tag_t head_tag;

  lsr_tx_flags u_tx (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .thr_wr(thr_wr),
    .tx_fifo_empty(tx_fifo_empty), .tsr_load(tsr_load), .tsr_done(tsr_done),
    .thr_irq_en(thr_irq_en), .thre(thre), .temt(temt), .tx_irq(tx_irq)
  );

  lsr_rx_tags #(.DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_tag(err_tag_t'(rx_tag)),
    .rx_pop(rx_pop), .lsr_rd(lsr_rd), .head_tag(head_tag), .err_any(err_any)
  );

  assign err_par = head_tag.par;
  assign err_frm = head_tag.frm;
  assign err_brk = head_tag.brk;

  assert_irq_needs_thre_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> temt || thre);
endmodule

// File: tb/tb_uart_line_status.sv
`timescale 1ns/1ps
module tb_uart_line_status;
  localparam int DEPTH = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_mode = 0, thr_wr = 0, tx_fifo_empty = 1, tsr_load = 0, tsr_done = 0;
  logic thr_irq_en = 0, rx_push = 0, rx_pop = 0, lsr_rd = 0;
  logic [2:0] rx_tag = 0;
  logic thre, temt, err_par, err_frm, err_brk, err_any, tx_irq;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic m_hold = 0, m_busy = 0, m_any = 0;
  logic [2:0] q [$];
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  uart_line_status #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int err_entries();
    int c = 0;
    foreach (q[i]) if (q[i] != 3'b000) c++;
    return c;
  endfunction

  // inputs already driven at negedge; check at negedge+1, model update at posedge
  task automatic cycle();
    logic e_thre;
    logic [2:0] head;
    string rq;
    #1;
    e_thre = fifo_mode ? tx_fifo_empty : ~m_hold;
    chk(fifo_mode ? "R3 thre" : "R2 thre", thre, e_thre);
    chk("R4 temt", temt, e_thre & ~m_busy);
    chk("R5 tx_irq", tx_irq, e_thre & thr_irq_en);
    head = (q.size() != 0) ? q[0] : 3'b000;
    rq = (lsr_rd && rx_pop) ? "R9" : "R6/R7";
    chk({rq, " err_par"}, err_par, head[0]);
    chk({rq, " err_frm"}, err_frm, head[1]);
    chk({rq, " err_brk"}, err_brk, head[2]);
    chk((lsr_rd && rx_pop) ? "R9 err_any" : "R8 err_any", err_any, m_any);
    @(posedge clk);
    begin
      logic popped = 0;
      if (fifo_mode) m_hold = 0;
      else if (thr_wr) m_hold = 1;
      else if (tsr_load) m_hold = 0;
      if (tsr_load) m_busy = 1; else if (tsr_done) m_busy = 0;
      if (rx_pop && q.size() != 0) begin void'(q.pop_front()); popped = 1; end
      if (rx_push && (q.size() < DEPTH)) q.push_back(rx_tag);
      m_any = (m_any & ~lsr_rd) | (err_entries() != 0);
    end
    @(negedge clk);
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic idle();
    {thr_wr, tsr_load, tsr_done, rx_push, rx_pop, lsr_rd} = '0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    chk("R1 thre", thre, 1'b1);
    chk("R1 temt", temt, 1'b1);
    chk("R1 err_par", err_par, 1'b0);
    chk("R1 err_frm", err_frm, 1'b0);
    chk("R1 err_brk", err_brk, 1'b0);
    chk("R1 err_any", err_any, 1'b0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // transmit sweep: all strobe and enable combinations, both modes
    for (int m = 0; m < 2; m++) begin
      fifo_mode = m[0];
      for (int i = 0; i < 64; i++) begin
        {thr_wr, tsr_load, tsr_done, thr_irq_en, tx_fifo_empty} = {i[3:0], i[4] ^ i[5]};
        cycle();
      end
    end
    idle(); fifo_mode = 0;
    // receive: fill past full with every tag value, status read, drain
    for (int i = 0; i < DEPTH + 3; i++) begin
      rx_push = 1; rx_tag = 3'(i + 1); cycle();
    end
    idle(); lsr_rd = 1; cycle();
    idle();
    for (int i = 0; i < DEPTH + 2; i++) begin
      rx_pop = 1; lsr_rd = i[0]; cycle();
    end
    idle(); lsr_rd = 1; cycle(); idle(); cycle();
    // full and push+pop together, then read+pop coinciding
    for (int i = 0; i < DEPTH; i++) begin rx_push = 1; rx_tag = 3'(i % 3); cycle(); end
    rx_push = 1; rx_pop = 1; lsr_rd = 1; rx_tag = 3'b100; cycle();
    idle();
    // mixed pseudo-random traffic on every input
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = rnd();
      fifo_mode = (i >= 2000);
      thr_wr = r[0]; tsr_load = r[1]; tsr_done = r[2]; thr_irq_en = r[3];
      tx_fifo_empty = r[4];
      rx_push = r[5] | r[6]; rx_pop = r[7] & r[8]; lsr_rd = r[9] & r[10];
      rx_tag = (r[11] | r[12]) ? 3'b000 : r[15:13];
      cycle();
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule